// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate with Round and Clamp

This block multiplies two signed 16-bit operands and adds the product to a wide accumulator each cycle. The operands are already fetched by the surrounding datapath. The accumulator keeps five bits of headroom above the full 32-bit product, so it is 37 bits wide. A dot product of a dozen or more full-scale terms therefore never wraps before it is written out.

A 3-bit operation code selects one of five actions:

- do nothing;
- zero the accumulator;
- add the product;
- replace the accumulator with the product;
- emit a 16-bit result.

The emitted value treats the operands and the result as Q15 fractions. It first rounds the accumulator to the nearest Q15 step, with halves going upward. It then clamps to the 16-bit range and raises a flag when the clamp acted. Rounding always comes before clamping. The sign extension of the product matches the accumulator width exactly.

Top module: `mac_guard`

## Requirements
- R1: While reset is low, and after it is released with no other operation, the outputs `result`, `resultValid` and `satHit` are all 0 and the accumulator is zero.
- R2: Operation code 2 (accumulate) adds the signed 32-bit product `opA*opB`, sign-extended to 37 bits, to the accumulator at the clock edge.
- R3: Operation code 1 (clear) sets the accumulator to zero, so that an emit in the next cycle yields 0 with `satHit` low.
- R4: Operation code 3 (load) replaces the accumulator with the product of the same cycle. No earlier contents survive.
- R5: Operation code 4 (emit) drives `resultValid` high for exactly the cycle after it, with the new `result` and `satHit`. The accumulator is left unchanged. `result` holds its value between emits.
- R6: The rounded value is the accumulator plus 2^14, arithmetically shifted right by 15 bits. A value of +0x4000 therefore gives 1, and -0x4000 gives 0.
- R7: When the rounded value is above 32767 or below -32768, `result` is 0x7FFF or 0x8000 respectively and `satHit` is 1. Otherwise `satHit` is 0.
- R8: Rounding happens before clamping. An accumulator of 0x3FFFC000 gives 0x7FFF with `satHit` set, not a wrapped 0x8000.
- R9: Operation code 0 (idle) and the unused codes 5 to 7 leave the accumulator unchanged and produce no `resultValid`, whatever the operands are.
- R10: A 13-term dot product is exact in the accumulator. Thirteen products of -32768 by -32768 give 0x7FFF, and partial sums that leave the 16-bit range but come back give the exact rounded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code: 0 idle, 1 clear, 2 accumulate, 3 load, 4 emit |
| opA | input | 16 | Signed first operand |
| opB | input | 16 | Signed second operand |
| result | output | 16 | Rounded and clamped Q15 result |
| resultValid | output | 1 | High for one cycle after an emit |
| satHit | output | 1 | The current result was clamped |

## Verification
The load operation clears the accumulator and adds a new product in the same cycle. The risk is that a stale sum leaks into the new one, or that the new product is lost. The bench builds a large sum, issues a load with a distinct product, and emits. It judges the result against a model that holds only that single product. Emitting directly after the last accumulate checks that the product added in one cycle is visible to the rounding logic in the next.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_ACCUM = 3'd2,
    OP_LOAD  = 3'd3,
    OP_EMIT  = 3'd4
  } macOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic clrAcc;
    logic addProd;
    logic emit;
  } macCtrl_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic [2:0] op,
  output macCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    case (op)
      OP_CLEAR: ctrl.clrAcc = 1'b1;
      OP_ACCUM: ctrl.addProd = 1'b1;
      OP_LOAD: begin
        ctrl.clrAcc  = 1'b1;
        ctrl.addProd = 1'b1;
      end
      OP_EMIT: ctrl.emit = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mac_round_sat.sv
module mac_round_sat #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 5
) (
  input  logic [2*DATA_W+GUARD_W-1:0] accIn,
  output logic [DATA_W-1:0]           resOut,
  output logic                        satOut
);

  localparam int ACC_W  = 2*DATA_W + GUARD_W;
  localparam int FRAC   = DATA_W - 1;
  localparam int TOP_LO = FRAC + DATA_W - 1;
  localparam logic [ACC_W:0] HALF = {{ACC_W{1'b0}}, 1'b1} << (FRAC - 1);
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [ACC_W:0]        rounded;
  logic [ACC_W-TOP_LO:0] topBits;
  logic                  inRange;

  // One extra bit, so the half-step add cannot wrap at the very top
  assign rounded = {accIn[ACC_W-1], accIn} + HALF;
  assign topBits = rounded[ACC_W:TOP_LO];
  assign inRange = (&topBits) | ~(|topBits);

  always_comb begin
    if (inRange) begin
      resOut = rounded[TOP_LO:FRAC];
      satOut = 1'b0;
    end else begin
      resOut = rounded[ACC_W] ? NEG_MIN : POS_MAX;
      satOut = 1'b1;
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  macCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              satHit
);

  localparam int PROD_W = 2*DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prodExt;
  logic [ACC_W-1:0]         acc;
  logic [ACC_W-1:0]         accBase;
  logic [DATA_W-1:0]        resNext;
  logic                     satNext;

  assign prod    = $signed(opA) * $signed(opB);
  assign prodExt = {{GUARD_W{prod[PROD_W-1]}}, prod};
  assign accBase = ctrl.clrAcc ? '0 : acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (ctrl.addProd) begin
      acc <= accBase + prodExt;
    end else if (ctrl.clrAcc) begin
      acc <= '0;
    end
  end

  mac_round_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_rs (
    .accIn (acc),
    .resOut(resNext),
    .satOut(satNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      satHit      <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.emit;
      if (ctrl.emit) begin
        result <= resNext;
        satHit <= satNext;
      end
    end
  end

endmodule

// File: rtl/mac_guard.sv
module mac_guard
  import mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              satHit
);

  macCtrl_t ctrl;

  mac_ctrl u_ctrl (
    .op  (op),
    .ctrl(ctrl)
  );

  mac_datapath #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .resultValid(resultValid),
    .satHit     (satHit)
  );

endmodule

// File: rtl/mac_guard_chk.sv
module mac_guard_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        op,
  input logic [DATA_W-1:0] result,
  input logic              resultValid,
  input logic              satHit
);

  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  AST_VALID_AFTER_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    op == 3'd4 |=> resultValid); // R5

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    op != 3'd4 |=> !resultValid); // R9

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && satHit) |-> (result == POS_MAX || result == NEG_MIN)); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result)); // R5

  AST_CLEAR_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (op == 3'd4 && $past(op) == 3'd1) |=> (result == '0 && !satHit)); // R3

endmodule

bind mac_guard mac_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .op         (op),
  .result     (result),
  .resultValid(resultValid),
  .satHit     (satHit)
);

// File: tb/mac_guard_tb.sv
module mac_guard_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] val;
    logic        sat;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [15:0] result;
  logic        resultValid;
  logic        satHit;

  int       checks = 0;
  int       errors = 0;
  longint   model = 0;
  bit       finished = 0;
  expItem_t expQ[$];

  mac_guard u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .op         (op),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .resultValid(resultValid),
    .satHit     (satHit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic expItem_t refOut(longint v, string tag);
    expItem_t e;
    longint q;
    q = (v + 64'sd16384) >>> 15;
    e.tag = tag;
    if (q > 32767) begin
      e.val = 16'h7FFF; e.sat = 1'b1;
    end else if (q < -32768) begin
      e.val = 16'h8000; e.sat = 1'b1;
    end else begin
      e.val = q[15:0]; e.sat = 1'b0;
    end
    return e;
  endfunction

  // Driver: applies one operation and updates the reference model
  task automatic doOp(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                      input string tag);
    longint p;
    @(negedge clk);
    op = o; opA = x; opB = y;
    p = longint'($signed(x)) * longint'($signed(y));
    case (o)
      3'd1: model = 0;
      3'd2: model = model + p;
      3'd3: model = p;
      3'd4: expQ.push_back(refOut(model, tag));
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doOp(3'd0, 16'h1234, 16'h5678, "R9");
  endtask

  // Monitor: compares each emitted result with the head of the queue
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected valid: actual=%h expected=none", result);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (result !== e.val || satHit !== e.sat) begin
          errors++;
          $display("FAIL %s actual=%h sat=%b expected=%h sat=%b",
                   e.tag, result, satHit, e.val, e.sat);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (result !== 16'h0 || resultValid !== 1'b0 || satHit !== 1'b0) begin
      errors++;
      $display("FAIL R1 actual=%h/%b/%b expected=0000/0/0", result, resultValid, satHit);
    end
    rstN = 1'b1;
    idle(2);
    checks++;
    if (result !== 16'h0 || resultValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release actual=%h/%b expected=0000/0", result, resultValid);
    end
    doOp(3'd4, 0, 0, "R1");

    // R2: plain accumulation
    doOp(3'd1, 0, 0, "R3");
    doOp(3'd2, 16'd1000, 16'd2000, "R2");
    doOp(3'd2, 16'hFF00, 16'd300, "R2");
    doOp(3'd4, 0, 0, "R2");

    // R5: emit right after accumulate, emit twice leaves accumulator alone
    doOp(3'd2, 16'd20000, 16'd20000, "R5");
    doOp(3'd4, 0, 0, "R5");
    doOp(3'd4, 0, 0, "R5");

    // R9: idle and unused codes change nothing
    doOp(3'd0, 16'h7FFF, 16'h7FFF, "R9");
    doOp(3'd5, 16'h7FFF, 16'h7FFF, "R9");
    doOp(3'd6, 16'h8000, 16'h7FFF, "R9");
    doOp(3'd7, 16'h1111, 16'h2222, "R9");
    doOp(3'd4, 0, 0, "R9");

    // R3: clear
    doOp(3'd1, 16'h7FFF, 16'h7FFF, "R3");
    doOp(3'd4, 0, 0, "R3");

    // R4: load replaces a large sum (clear and add in the same cycle)
    for (int i = 0; i < 6; i++) doOp(3'd2, 16'h7FFF, 16'h7FFF, "R4");
    doOp(3'd3, 16'd300, 16'hFFF6, "R4");
    doOp(3'd4, 0, 0, "R4");

    // R6: half-step rounding both signs
    doOp(3'd3, 16'd128, 16'd128, "R6");
    doOp(3'd4, 0, 0, "R6");
    doOp(3'd3, 16'hFF80, 16'd128, "R6");
    doOp(3'd4, 0, 0, "R6");

    // R7: exact negative limit does not clamp; beyond it clamps
    doOp(3'd3, 16'h8000, 16'h7FFF, "R7");
    doOp(3'd2, 16'h8000, 16'd1, "R7");
    doOp(3'd4, 0, 0, "R7");
    doOp(3'd2, 16'h8000, 16'h7FFF, "R7");
    doOp(3'd4, 0, 0, "R7");

    // R8: 0x3FFFC000 rounds up past the limit, then clamps
    doOp(3'd3, 16'h7FFF, 16'h7FFF, "R8");
    doOp(3'd2, 16'h7FFF, 16'd1, "R8");
    doOp(3'd2, 16'd128, 16'd128, "R8");
    doOp(3'd4, 0, 0, "R8");

    // R10: thirteen full-scale terms, and an excursion that returns
    doOp(3'd1, 0, 0, "R10");
    for (int i = 0; i < 13; i++) doOp(3'd2, 16'h8000, 16'h8000, "R10");
    doOp(3'd4, 0, 0, "R10");
    doOp(3'd1, 0, 0, "R10");
    for (int i = 0; i < 6; i++) doOp(3'd2, 16'h8000, 16'h8000, "R10");
    for (int i = 0; i < 6; i++) doOp(3'd2, 16'h8000, 16'h7FFF, "R10");
    doOp(3'd2, 16'd5000, 16'd3000, "R10");
    doOp(3'd4, 0, 0, "R10");

    // R10: random 13-term sums, some biased toward overflow
    for (int s = 0; s < 40; s++) begin
      doOp(3'd1, 0, 0, "R10");
      for (int i = 0; i < 13; i++) begin
        logic [15:0] x, y;
        x = 16'($urandom);
        y = 16'($urandom);
        if (s % 3 == 0) begin
          x = {1'b0, 1'b1, x[13:0]};
          y = {1'b0, 1'b1, y[13:0]};
        end
        doOp((i == 0) ? 3'd3 : 3'd2, x, y, "R10");
      end
      doOp(3'd4, 0, 0, "R10");
    end

    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R5 missing results actual=%0d expected=0", expQ.size());
    end
    finish();
  end

endmodule